// File: doc/BRIEF.md
# Legacy I/O Interrupt Register Block

This block is the byte-wide register window of a legacy I/O chipset. A requester issues one access per cycle on a request/response bus: an address offset, a write flag, a size code and a byte of write data. The block answers each access one cycle later with a response pulse, read data and an error flag. Behind the window sits a simplified 8-source interrupt controller: a pending register, an enable mask and one interrupt output line. Side-band inputs let nearby devices post or withdraw interrupt sources without using the bus.

A second controller is present only as a stub, with a mask that can be stored and read back. The block also holds two latched DMA mode bytes and reports the speaker bit of port B from an external timer output. It forwards timer-counter accesses to an external counter block through strobes and returns that block's byte. Accesses to DMA control offsets that need no state are accepted and dropped. Any malformed access is refused with an error response and has no effect.

Top module: `lio_irq_regs`

## Requirements
- R1: Reset (active-low, asynchronous) clears the pending register and the enable mask to all zeros, deasserts `irq_o`, clears both DMA mode bytes and the secondary mask, and leaves `rsp_valid_o` low.
- R2: Every request cycle is answered by `rsp_valid_o` high for exactly the next cycle; in a cycle after no request `rsp_valid_o` is low. Size codes: 0 = byte, 1 and 2 = other widths, 3 = 64-bit.
- R3: A byte write to offset 0x21 stores the bitwise complement of the data as the enable mask (a written 1 masks that source); after it `irq_o` is high exactly when pending AND enable is nonzero. A byte read of 0x21 returns the stored enable mask.
- R4: A byte write to offset 0x20 clears the pending bit whose index is data[3:0] (index 8 to 15 clears nothing) and deasserts `irq_o` even if enabled sources remain pending.
- R5: A post (`post_valid_i`) ORs `post_vec_i` into pending and asserts `irq_o` if pending AND enable is then nonzero; a post never deasserts `irq_o`.
- R6: A clear (`clr_valid_i`) removes `clr_vec_i` from pending and deasserts `irq_o` if pending AND enable is then zero; a clear never asserts `irq_o`.
- R7: When a bus write and side-band inputs fall in the same cycle, the effects apply in the order bus write, then post, then clear.
- R8: A byte write to 0xA1 stores the data uninverted and never changes `irq_o`; a byte read of 0xA1 returns it and a byte read of 0xA0 returns 0.
- R9: A byte read or a 64-bit read of 0x20 returns the pending register zero-extended.
- R10: An error response (`rsp_err_o` high, read data 0, no state change) is given for any write not of size 0, any size 1 or 2 access, a 64-bit read at any offset but 0x20, a byte write to 0xA0, a byte read of 0x0B, 0xD6 or the ignored DMA offsets, and any undecoded offset.
- R11: A byte read of 0x61 returns 0x20 while `tmr2_out_i` is high and 0 while it is low; a byte write to 0x61 is accepted with no effect.
- R12: Byte writes to 0x0B and 0xD6 latch the data onto `dma_mode_a_o` and `dma_mode_b_o`; byte writes to 0x08, 0xD0, 0x0F, 0xDE, 0x0D, 0xDA, 0x0A and 0xD4 are accepted without error and change no output.
- R13: A byte access to 0x40 to 0x43 pulses `tmr_wr_o` (write) or `tmr_rd_o` (read) in the request cycle with `tmr_sel_o` equal to the offset's low two bits and `tmr_wdata_o` the write data; a read returns `tmr_rdata_i` as sampled in the request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access request this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_size_i | input | 2 | Size code: 0 byte, 1/2 other, 3 64-bit |
| req_addr_i | input | ADDR_W | Byte offset within the window |
| req_wdata_i | input | DATA_W | Write data byte |
| rsp_valid_o | output | 1 | Response pulse, one cycle after the request |
| rsp_err_o | output | 1 | Access refused |
| rsp_rdata_o | output | RSP_W | Read data, zero on writes and errors |
| post_valid_i | input | 1 | Post the sources in post_vec_i |
| post_vec_i | input | DATA_W | Sources to post |
| clr_valid_i | input | 1 | Withdraw the sources in clr_vec_i |
| clr_vec_i | input | DATA_W | Sources to withdraw |
| irq_o | output | 1 | Interrupt output line |
| tmr2_out_i | input | 1 | Timer channel 2 output level |
| tmr_rdata_i | input | DATA_W | Byte from the external timer block |
| tmr_wr_o | output | 1 | Timer write strobe |
| tmr_rd_o | output | 1 | Timer read strobe |
| tmr_sel_o | output | 2 | Timer register select |
| tmr_wdata_o | output | DATA_W | Timer write data |
| dma_mode_a_o | output | DATA_W | First latched DMA mode byte |
| dma_mode_b_o | output | DATA_W | Second latched DMA mode byte |

## Verification
A corrupted pending bit shows on the next read of 0x20 and, if enabled, as a wrong `irq_o` level one cycle after the next post, clear or mask write. A lost inversion of the mask shows immediately as an `irq_o` of the wrong polarity after the mask write and as the wrong byte on a read of 0x21. The ack path is the hardest to see, since a missed deassertion leaves `irq_o` high and is only exposed when the bench acks with enabled sources still pending and samples `irq_o` the cycle after. A broken decode shows in the very next response as an error flag where none was due, or the reverse.

// File: rtl/lio_pkg.sv
package lio_pkg;

  localparam logic [1:0] SZ_BYTE  = 2'd0;
  localparam logic [1:0] SZ_DWORD = 2'd3;

  localparam logic [7:0] OFS_PSTAT = 8'h20;
  localparam logic [7:0] OFS_PMASK = 8'h21;
  localparam logic [7:0] OFS_SSTAT = 8'hA0;
  localparam logic [7:0] OFS_SMASK = 8'hA1;
  localparam logic [7:0] OFS_DMA_A = 8'h0B;
  localparam logic [7:0] OFS_DMA_B = 8'hD6;
  localparam logic [7:0] OFS_PORTB = 8'h61;
  localparam logic [7:0] OFS_TMR   = 8'h40;

  localparam logic [7:0] PORTB_SPK_HI = 8'h20;

  // latch bank slots
  localparam int LB_DMA_A = 0;
  localparam int LB_DMA_B = 1;
  localparam int LB_SMASK = 2;
  localparam int LB_NUM   = 3;

  typedef enum logic [3:0] {
    OP_NONE,
    OP_ERR,
    OP_PSTAT,
    OP_PMASK,
    OP_SSTAT,
    OP_SMASK,
    OP_DMA_A,
    OP_DMA_B,
    OP_TMR,
    OP_PORTB,
    OP_IGNORE
  } lio_op_e;

endpackage

// File: rtl/lio_decode.sv
module lio_decode
  import lio_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              valid_i,
  input  logic              write_i,
  input  logic [1:0]        size_i,
  input  logic [ADDR_W-1:0] addr_i,
  output lio_op_e           op_o
);

  localparam logic [ADDR_W-1:0] A_PSTAT = ADDR_W'(OFS_PSTAT);
  localparam logic [ADDR_W-1:0] A_PMASK = ADDR_W'(OFS_PMASK);
  localparam logic [ADDR_W-1:0] A_SSTAT = ADDR_W'(OFS_SSTAT);
  localparam logic [ADDR_W-1:0] A_SMASK = ADDR_W'(OFS_SMASK);
  localparam logic [ADDR_W-1:0] A_DMA_A = ADDR_W'(OFS_DMA_A);
  localparam logic [ADDR_W-1:0] A_DMA_B = ADDR_W'(OFS_DMA_B);
  localparam logic [ADDR_W-1:0] A_PORTB = ADDR_W'(OFS_PORTB);
  localparam logic [ADDR_W-3:0] A_TMR_HI = (ADDR_W-2)'(OFS_TMR >> 2);
  // DMA control offsets that are written but hold no state
  localparam logic [ADDR_W-1:0] A_IG0 = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_IG1 = ADDR_W'(8'hD0);
  localparam logic [ADDR_W-1:0] A_IG2 = ADDR_W'(8'h0F);
  localparam logic [ADDR_W-1:0] A_IG3 = ADDR_W'(8'hDE);
  localparam logic [ADDR_W-1:0] A_IG4 = ADDR_W'(8'h0D);
  localparam logic [ADDR_W-1:0] A_IG5 = ADDR_W'(8'hDA);
  localparam logic [ADDR_W-1:0] A_IG6 = ADDR_W'(8'h0A);
  localparam logic [ADDR_W-1:0] A_IG7 = ADDR_W'(8'hD4);

  logic is_tmr;
  assign is_tmr = (addr_i[ADDR_W-1:2] == A_TMR_HI);

  always_comb begin
    op_o = OP_NONE;
    if (valid_i) begin
      op_o = OP_ERR;
      if (size_i == SZ_DWORD) begin
        if (!write_i && addr_i == A_PSTAT) op_o = OP_PSTAT;
      end else if (size_i == SZ_BYTE) begin
        if (is_tmr) begin
          op_o = OP_TMR;
        end else begin
          case (addr_i)
            A_PSTAT: op_o = OP_PSTAT;
            A_PMASK: op_o = OP_PMASK;
            A_SSTAT: op_o = write_i ? OP_ERR : OP_SSTAT;
            A_SMASK: op_o = OP_SMASK;
            A_DMA_A: op_o = write_i ? OP_DMA_A : OP_ERR;
            A_DMA_B: op_o = write_i ? OP_DMA_B : OP_ERR;
            A_PORTB: op_o = OP_PORTB;
            A_IG0, A_IG1, A_IG2, A_IG3,
            A_IG4, A_IG5, A_IG6, A_IG7: op_o = write_i ? OP_IGNORE : OP_ERR;
            default: op_o = OP_ERR;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/lio_pic.sv
module lio_pic #(
  parameter int SRC_W = 8,
  parameter int IDX_W = $clog2(SRC_W) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mask_we_i,
  input  logic [SRC_W-1:0] mask_wdata_i,
  input  logic             ack_we_i,
  input  logic [IDX_W-1:0] ack_idx_i,
  input  logic             post_valid_i,
  input  logic [SRC_W-1:0] post_vec_i,
  input  logic             clr_valid_i,
  input  logic [SRC_W-1:0] clr_vec_i,
  output logic [SRC_W-1:0] pend_o,
  output logic [SRC_W-1:0] en_o,
  output logic             irq_o
);

  logic [SRC_W-1:0] pend_q, en_q, ack_dec;
  logic [SRC_W-1:0] pend_n, en_n;
  logic             irq_q, irq_n;

  // index beyond SRC_W decodes to no bit
  for (genvar k = 0; k < SRC_W; k++) begin : g_ack
    assign ack_dec[k] = (ack_idx_i == IDX_W'(k));
  end

  // fold: bus write, then post, then clear
  always_comb begin
    pend_n = pend_q;
    en_n   = en_q;
    irq_n  = irq_q;
    if (mask_we_i) begin
      en_n = ~mask_wdata_i;
      if (|(pend_n & en_n)) begin
        if (!irq_n) irq_n = 1'b1;
      end else if (irq_n) begin
        irq_n = 1'b0;
      end
    end
    if (ack_we_i) begin
      pend_n = pend_n & ~ack_dec;
      irq_n  = 1'b0;
    end
    if (post_valid_i) begin
      pend_n = pend_n | post_vec_i;
      if (|(pend_n & en_n)) irq_n = 1'b1;
    end
    if (clr_valid_i) begin
      pend_n = pend_n & ~clr_vec_i;
      if (!(|(pend_n & en_n))) irq_n = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      en_q   <= '0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_n;
      en_q   <= en_n;
      irq_q  <= irq_n;
    end
  end

  assign pend_o = pend_q;
  assign en_o   = en_q;
  assign irq_o  = irq_q;

endmodule

// File: rtl/lio_latch_bank.sv
module lio_latch_bank #(
  parameter int NUM  = 3,
  parameter int DW   = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NUM-1:0]          we_i,
  input  logic [DW-1:0]           wdata_i,
  output logic [NUM-1:0][DW-1:0]  q_o
);

  for (genvar i = 0; i < NUM; i++) begin : g_reg
    logic [DW-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    q <= '0;
      else if (we_i[i]) q <= wdata_i;
    end
    assign q_o[i] = q;
  end

endmodule

// File: rtl/lio_irq_regs.sv
module lio_irq_regs
  import lio_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int RSP_W  = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [1:0]        req_size_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic              rsp_err_o,
  output logic [RSP_W-1:0]  rsp_rdata_o,
  input  logic              post_valid_i,
  input  logic [DATA_W-1:0] post_vec_i,
  input  logic              clr_valid_i,
  input  logic [DATA_W-1:0] clr_vec_i,
  output logic              irq_o,
  input  logic              tmr2_out_i,
  input  logic [DATA_W-1:0] tmr_rdata_i,
  output logic              tmr_wr_o,
  output logic              tmr_rd_o,
  output logic [1:0]        tmr_sel_o,
  output logic [DATA_W-1:0] tmr_wdata_o,
  output logic [DATA_W-1:0] dma_mode_a_o,
  output logic [DATA_W-1:0] dma_mode_b_o
);

  localparam int IDX_W = $clog2(DATA_W) + 1;
  localparam int PAD_W = RSP_W - DATA_W;

  lio_op_e                    op;
  logic [DATA_W-1:0]          pend_w, en_w;
  logic [LB_NUM-1:0]          lb_we;
  logic [LB_NUM-1:0][DATA_W-1:0] lb_q;
  logic                       wr;
  logic [DATA_W-1:0]          rbyte;

  lio_decode #(.ADDR_W(ADDR_W)) u_dec (
    .valid_i (req_valid_i),
    .write_i (req_write_i),
    .size_i  (req_size_i),
    .addr_i  (req_addr_i),
    .op_o    (op)
  );

  assign wr = req_write_i;

  lio_pic #(.SRC_W(DATA_W), .IDX_W(IDX_W)) u_pic (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mask_we_i    (op == OP_PMASK && wr),
    .mask_wdata_i (req_wdata_i),
    .ack_we_i     (op == OP_PSTAT && wr),
    .ack_idx_i    (req_wdata_i[IDX_W-1:0]),
    .post_valid_i (post_valid_i),
    .post_vec_i   (post_vec_i),
    .clr_valid_i  (clr_valid_i),
    .clr_vec_i    (clr_vec_i),
    .pend_o       (pend_w),
    .en_o         (en_w),
    .irq_o        (irq_o)
  );

  always_comb begin
    lb_we           = '0;
    lb_we[LB_DMA_A] = (op == OP_DMA_A) && wr;
    lb_we[LB_DMA_B] = (op == OP_DMA_B) && wr;
    lb_we[LB_SMASK] = (op == OP_SMASK) && wr;
  end

  lio_latch_bank #(.NUM(LB_NUM), .DW(DATA_W)) u_lb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (lb_we),
    .wdata_i (req_wdata_i),
    .q_o     (lb_q)
  );

  assign dma_mode_a_o = lb_q[LB_DMA_A];
  assign dma_mode_b_o = lb_q[LB_DMA_B];

  assign tmr_wr_o    = (op == OP_TMR) && wr;
  assign tmr_rd_o    = (op == OP_TMR) && !wr;
  assign tmr_sel_o   = req_addr_i[1:0];
  assign tmr_wdata_o = req_wdata_i;

  always_comb begin
    rbyte = '0;
    if (!wr) begin
      case (op)
        OP_PSTAT: rbyte = pend_w;
        OP_PMASK: rbyte = en_w;
        OP_SMASK: rbyte = lb_q[LB_SMASK];
        OP_TMR:   rbyte = tmr_rdata_i;
        OP_PORTB: rbyte = tmr2_out_i ? DATA_W'(PORTB_SPK_HI) : '0;
        default:  rbyte = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_err_o   <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_err_o   <= (op == OP_ERR);
      rsp_rdata_o <= {{PAD_W{1'b0}}, rbyte};
    end
  end

endmodule

// File: rtl/lio_irq_regs_chk.sv
module lio_irq_regs_chk
  import lio_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int RSP_W  = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_write_i,
  input logic [1:0]        req_size_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              post_valid_i,
  input logic [DATA_W-1:0] post_vec_i,
  input logic              clr_valid_i,
  input logic              tmr2_out_i,
  input logic              rsp_valid_o,
  input logic              rsp_err_o,
  input logic [RSP_W-1:0]  rsp_rdata_o,
  input logic              irq_o,
  input logic [DATA_W-1:0] pend_i,
  input logic [DATA_W-1:0] en_i
);

  logic byte_wr, byte_rd, quiet;
  assign byte_wr = req_valid_i && req_write_i && req_size_i == SZ_BYTE;
  assign byte_rd = req_valid_i && !req_write_i && req_size_i == SZ_BYTE;
  assign quiet   = !post_valid_i && !clr_valid_i;

  AST_RSP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o); // R2
  AST_RSP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o); // R2
  AST_IRQ_BACKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> |(pend_i & en_i)); // R6
  AST_ACK_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_wr && req_addr_i == ADDR_W'(OFS_PSTAT) && !post_valid_i) |=> !irq_o); // R4
  AST_POST_RAISES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (post_valid_i && |(post_vec_i & en_i) && !clr_valid_i && !req_valid_i) |=> irq_o); // R5
  AST_SMASK_NO_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_wr && req_addr_i == ADDR_W'(OFS_SMASK) && quiet) |=> $stable(irq_o)); // R8
  AST_BAD_SIZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && (req_size_i == 2'd1 || req_size_i == 2'd2) && quiet)
    |=> rsp_err_o && $stable(pend_i) && $stable(en_i) && $stable(irq_o)); // R10
  AST_WIDE_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i && req_size_i == SZ_DWORD && req_addr_i == ADDR_W'(OFS_PSTAT))
    |=> rsp_rdata_o == RSP_W'($past(pend_i))); // R9
  AST_PORTB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_rd && req_addr_i == ADDR_W'(OFS_PORTB))
    |=> rsp_rdata_o == ($past(tmr2_out_i) ? RSP_W'(PORTB_SPK_HI) : '0)); // R11

endmodule

bind lio_irq_regs lio_irq_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RSP_W(RSP_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_write_i  (req_write_i),
  .req_size_i   (req_size_i),
  .req_addr_i   (req_addr_i),
  .post_valid_i (post_valid_i),
  .post_vec_i   (post_vec_i),
  .clr_valid_i  (clr_valid_i),
  .tmr2_out_i   (tmr2_out_i),
  .rsp_valid_o  (rsp_valid_o),
  .rsp_err_o    (rsp_err_o),
  .rsp_rdata_o  (rsp_rdata_o),
  .irq_o        (irq_o),
  .pend_i       (pend_w),
  .en_i         (en_w)
);

// File: tb/lio_irq_regs_test.sv
module lio_irq_regs_test;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [1:0]  req_size;
  logic [7:0]  req_addr, req_wdata;
  logic        rsp_valid, rsp_err;
  logic [63:0] rsp_rdata;
  logic        post_valid, clr_valid;
  logic [7:0]  post_vec, clr_vec;
  logic        irq;
  logic        tmr2;
  logic [7:0]  tmr_rdata;
  logic        tmr_wr, tmr_rd;
  logic [1:0]  tmr_sel;
  logic [7:0]  tmr_wdata, dma_a, dma_b;

  always #(CLK_P/2) clk = ~clk;

  lio_irq_regs uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_size_i(req_size),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err), .rsp_rdata_o(rsp_rdata),
    .post_valid_i(post_valid), .post_vec_i(post_vec),
    .clr_valid_i(clr_valid), .clr_vec_i(clr_vec),
    .irq_o(irq), .tmr2_out_i(tmr2), .tmr_rdata_i(tmr_rdata),
    .tmr_wr_o(tmr_wr), .tmr_rd_o(tmr_rd), .tmr_sel_o(tmr_sel), .tmr_wdata_o(tmr_wdata),
    .dma_mode_a_o(dma_a), .dma_mode_b_o(dma_b)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  logic [64:0] exp_q[$];
  string       tag_q[$];

  // reference state
  logic [7:0] m_pend, m_en, m_smask, m_da, m_db;
  logic       m_irq;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit legal(bit wr, logic [1:0] sz, logic [7:0] a);
    if (wr) begin
      if (sz != 2'd0) return 0;
      return a inside {8'h20, 8'h21, 8'hA1, 8'h0B, 8'hD6, 8'h40, 8'h41, 8'h42, 8'h43,
                       8'h61, 8'h08, 8'hD0, 8'h0F, 8'hDE, 8'h0D, 8'hDA, 8'h0A, 8'hD4};
    end
    if (sz == 2'd3) return a == 8'h20;
    if (sz != 2'd0) return 0;
    return a inside {8'h20, 8'h21, 8'hA0, 8'hA1, 8'h40, 8'h41, 8'h42, 8'h43, 8'h61};
  endfunction

  function automatic logic [63:0] rd_val(logic [7:0] a);
    case (a)
      8'h20: return 64'(m_pend);
      8'h21: return 64'(m_en);
      8'hA1: return 64'(m_smask);
      8'h40, 8'h41, 8'h42, 8'h43: return 64'(tmr_rdata);
      8'h61: return tmr2 ? 64'h20 : 64'h0;
      default: return 64'h0;
    endcase
  endfunction

  task automatic apply_side(logic [7:0] pv, logic [7:0] cv);
    if (pv != 0) begin
      m_pend = m_pend | pv;
      if ((m_pend & m_en) != 0) m_irq = 1'b1;
    end
    if (cv != 0) begin
      m_pend = m_pend & ~cv;
      if ((m_pend & m_en) == 0) m_irq = 1'b0;
    end
  endtask

  task automatic bus(bit wr, logic [1:0] sz, logic [7:0] a, logic [7:0] d, string tag,
                     logic [7:0] pv = 8'h0, logic [7:0] cv = 8'h0);
    bit ok, is_t;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = d;
    post_valid = (pv != 0); post_vec = pv; clr_valid = (cv != 0); clr_vec = cv;
    ok   = legal(wr, sz, a);
    is_t = ok && (a[7:2] == 6'h10);
    exp_q.push_back({!ok, (ok && !wr) ? rd_val(a) : 64'h0});
    tag_q.push_back(tag);
    #1;
    chk("R13 tmr_wr strobe", 64'(tmr_wr), 64'(is_t && wr));
    chk("R13 tmr_rd strobe", 64'(tmr_rd), 64'(is_t && !wr));
    if (is_t) begin
      chk("R13 tmr_sel", 64'(tmr_sel), 64'(a[1:0]));
      if (wr) chk("R13 tmr_wdata", 64'(tmr_wdata), 64'(d));
    end
    if (ok && wr) begin
      case (a)
        8'h21: begin m_en = ~d; m_irq = ((m_pend & m_en) != 0); end
        8'h20: begin if (d[3:0] < 4'd8) m_pend[d[2:0]] = 1'b0; m_irq = 1'b0; end
        8'hA1: m_smask = d;
        8'h0B: m_da = d;
        8'hD6: m_db = d;
        default: ;
      endcase
    end
    apply_side(pv, cv);
    @(negedge clk);
    req_valid = 1'b0; post_valid = 1'b0; clr_valid = 1'b0;
    chk({tag, " irq"}, 64'(irq), 64'(m_irq));
    chk("R12 dma_a", 64'(dma_a), 64'(m_da));
    chk("R12 dma_b", 64'(dma_b), 64'(m_db));
  endtask

  task automatic side(logic [7:0] pv, logic [7:0] cv, string tag);
    @(negedge clk);
    post_valid = (pv != 0); post_vec = pv; clr_valid = (cv != 0); clr_vec = cv;
    apply_side(pv, cv);
    @(negedge clk);
    post_valid = 1'b0; clr_valid = 1'b0;
    chk({tag, " irq"}, 64'(irq), 64'(m_irq));
  endtask

  // monitor: pops expected responses
  logic [64:0] mon_e;
  string       mon_t;
  always @(negedge clk) begin
    if (rst_n && !done && rsp_valid) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R2 unexpected response actual=1 expected=0");
      end else begin
        mon_e = exp_q.pop_front();
        mon_t = tag_q.pop_front();
        chk({mon_t, " err"}, 64'(rsp_err), 64'(mon_e[64]));
        chk({mon_t, " rdata"}, rsp_rdata, mon_e[63:0]);
      end
    end
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      done = 1; checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 0; req_write = 0; req_size = 0; req_addr = 0; req_wdata = 0;
    post_valid = 0; post_vec = 0; clr_valid = 0; clr_vec = 0; tmr2 = 0; tmr_rdata = 0;
    m_pend = 0; m_en = 0; m_smask = 0; m_da = 0; m_db = 0; m_irq = 0;
    #(CLK_P * 3);
    chk("R1 irq in reset", 64'(irq), 0);
    chk("R1 rsp_valid in reset", 64'(rsp_valid), 0);
    chk("R1 dma_a in reset", 64'(dma_a), 0);
    @(negedge clk); rst_n = 1'b1;

    bus(0, 0, 8'h21, 0, "R1 enable reset value");
    bus(0, 0, 8'h20, 0, "R1 pending reset value");
    bus(0, 0, 8'hA1, 0, "R1 secondary mask reset");

    // post while masked
    side(8'h05, 8'h00, "R5 post masked");
    bus(0, 0, 8'h20, 0, "R9 byte pending read");
    bus(1, 0, 8'h21, 8'hFE, "R3 unmask bit0");
    chk("R3 irq literal", 64'(irq), 1);
    bus(0, 0, 8'h21, 0, "R3 enable readback");
    bus(1, 0, 8'h20, 8'h00, "R4 ack bit0");
    bus(1, 0, 8'h21, 8'hFB, "R3 unmask bit2");
    bus(1, 0, 8'h20, 8'h12, "R4 ack idx2 high nibble");
    bus(0, 0, 8'h20, 0, "R4 pending after acks");

    // ack with enabled sources left
    side(8'h03, 8'h00, "R5 post 03");
    bus(1, 0, 8'h21, 8'h00, "R3 unmask all");
    bus(1, 0, 8'h20, 8'h01, "R4 ack leaves pending");
    chk("R4 irq low with pending", 64'(irq), 0);
    bus(1, 0, 8'h20, 8'h0B, "R4 ack index 11");
    bus(0, 3, 8'h20, 0, "R9 wide read");

    // clear rules
    side(8'h02, 8'h00, "R5 post raises");
    side(8'h00, 8'h01, "R6 clear keeps");
    side(8'h00, 8'h02, "R6 clear drops");
    bus(1, 0, 8'h21, 8'hFF, "R3 mask all");
    side(8'h10, 8'h00, "R5 post fully masked");
    side(8'h00, 8'h80, "R6 clear never raises");

    // same-cycle ordering
    bus(1, 0, 8'h21, 8'h00, "R3 unmask all again");
    bus(1, 0, 8'h20, 8'h04, "R7 ack then post", 8'h10, 8'h00);
    chk("R7 irq after ack+post", 64'(irq), 1);
    bus(1, 0, 8'h21, 8'hEF, "R7 mask then clear", 8'h00, 8'h11);
    bus(0, 0, 8'h20, 0, "R7 pending after fold");

    // secondary controller
    side(8'h20, 8'h00, "R5 post 20");
    bus(1, 0, 8'hA1, 8'h5A, "R8 secondary mask write");
    bus(0, 0, 8'hA1, 0, "R8 secondary mask read");
    bus(0, 0, 8'hA0, 0, "R8 secondary status read");

    // illegal accesses
    bus(1, 3, 8'h21, 8'hFF, "R10 wide write");
    bus(0, 0, 8'h21, 0, "R10 enable unchanged");
    bus(1, 0, 8'h30, 8'h00, "R10 undecoded write");
    bus(0, 3, 8'h21, 0, "R10 wide read elsewhere");
    bus(0, 0, 8'h0B, 0, "R10 read write-only");
    bus(0, 1, 8'h20, 0, "R10 half read");
    bus(1, 2, 8'h20, 8'h05, "R10 word write");
    bus(1, 0, 8'hA0, 8'h00, "R10 write secondary status");
    bus(0, 0, 8'h08, 0, "R10 read ignored offset");

    // port B
    tmr2 = 1'b1;
    bus(0, 0, 8'h61, 0, "R11 portb high");
    tmr2 = 1'b0;
    bus(0, 0, 8'h61, 0, "R11 portb low");
    bus(1, 0, 8'h61, 8'hFF, "R11 portb write");

    // DMA latches and ignored offsets
    bus(1, 0, 8'h0B, 8'h47, "R12 dma mode a");
    bus(1, 0, 8'hD6, 8'h99, "R12 dma mode b");
    foreach (tag_q[i]) ; // no-op
    bus(1, 0, 8'h08, 8'h11, "R12 ignored cmd");
    bus(1, 0, 8'hDA, 8'h22, "R12 ignored reset");
    bus(1, 0, 8'h0A, 8'h33, "R12 ignored mask");
    bus(1, 0, 8'hDE, 8'h44, "R12 ignored mmask");

    // timer pass-through
    tmr_rdata = 8'h3C;
    bus(0, 0, 8'h42, 0, "R13 timer read");
    bus(1, 0, 8'h43, 8'h36, "R13 timer write");
    tmr_rdata = 8'hC5;
    bus(0, 0, 8'h40, 0, "R13 timer read 0");

    repeat (3) @(negedge clk);
    chk("R2 all responses seen", 64'(exp_q.size()), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule